// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and status section of a small 8-bit accumulator machine. It decodes one instruction byte per execute strobe. It computes one of sixteen functions on the two data registers A and B and presents the result with a flag that says which register should take it. The block holds the carry, negative and zero status bits itself. The register file around it owns A and B and applies the result. That register file uses the destination select and write enable to decide where the byte goes.

The block also runs the carry-manipulation group of the instruction set. This group can load carry from an input pin, from a status bit or from the pointer-equality flag. It can set, clear or invert carry, and it can latch carry onto one of four output pins. Any other instruction byte that reaches the block leaves every status bit and every pin as it was.

Top module: `accum_flag_alu`

## Requirements
- R1: With instruction bits [7:5] = 000, bits [3:0] choose the result as follows: 0 gives A, 1 gives ~A, 2 gives B, 3 gives ~B, 4 gives A+B+C, 5 gives A-B-C, 6 gives A&B and 7 gives A|B. C is the carry flag held before the instruction.
- R2: Function codes 8, 9, 10 and 11 give four rotations of A. Code 8 rotates right by one and code 9 rotates left by one. Code 10 rotates right through carry, so C enters bit 7. Code 11 rotates left through carry, so C enters bit 0.
- R3: Function codes 12, 13, 14 and 15 give A+1, A-1, B+1 and B-1, each modulo 256.
- R4: The result write strobe is high only while the execute strobe is high and instruction bits [7:5] = 000. The destination select equals instruction bit 4 (0 = A, 1 = B).
- R5: On an executed ALU instruction, carry takes the following value one cycle later. For codes 4 and 12 to 15 it is the carry or borrow out of bit 7. For code 5 it is set on a borrow. For codes 10 and 11 it is the bit shifted out. For codes 0 to 3 and 6 to 9 it is 0.
- R6: Every executed ALU instruction loads N with result bit 7 and Z with (result == 0). No other instruction changes N or Z.
- R7: With instruction bits [7:4] = 0110, operands 0 and 1 copy input pin 0 or 1 into C. Operands 2, 3 and 4 copy N, Z or the pointer-equality input into C.
- R8: Operands 5, 6 and 7 of group 0110 clear, set and invert C.
- R9: Operand 10nn of group 0110 latches C onto output pin nn. Each pin holds its value until it is written again.
- R10: Operands 11xx of group 0110 change no state. Neither do opcode groups 0010 to 0101 or 0111 to 1111, or any byte presented while the execute strobe is low.
- R11: After reset C, N, Z and all output pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr | input | 8 | Instruction byte |
| exec_en | input | 1 | Execute strobe, one instruction per high cycle |
| a_in | input | 8 | Register A value |
| b_in | input | 8 | Register B value |
| pin_in | input | 2 | Input pins readable into carry |
| ptr_eq | input | 1 | Pointer-equality status from the pointer unit |
| res_out | output | 8 | ALU result (combinational) |
| res_wr | output | 1 | Result write strobe |
| res_to_b | output | 1 | Destination select, 1 = B |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| pin_out | output | 4 | Registered output pins |

## Verification
Carry is both an input to four functions and a result of all of them. A wrong carry therefore shows up twice. It appears on flag_c one cycle after the faulty instruction. It appears again in res_out of the next add, subtract or rotate through carry, which the random mix brings up within a few instructions. A stray update of N or Z, or a wrongly held value in either, appears on the flag pins one cycle after the disturbing byte. An error in a pin latch stays visible on pin_out until that pin is written again.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
  typedef enum logic [3:0] {
    FN_PASS_A = 4'h0, FN_NOT_A = 4'h1, FN_PASS_B = 4'h2, FN_NOT_B = 4'h3,
    FN_ADD    = 4'h4, FN_SUB   = 4'h5, FN_AND    = 4'h6, FN_OR    = 4'h7,
    FN_ROR    = 4'h8, FN_ROL   = 4'h9, FN_RORC   = 4'hA, FN_ROLC  = 4'hB,
    FN_INC_A  = 4'hC, FN_DEC_A = 4'hD, FN_INC_B  = 4'hE, FN_DEC_B = 4'hF
  } alu_fn_e;

  // carry source selections within the carry group (operand bit 3 = 0)
  typedef enum logic [2:0] {
    CY_PIN0 = 3'd0, CY_PIN1 = 3'd1, CY_NEG  = 3'd2, CY_ZERO = 3'd3,
    CY_PEQ  = 3'd4, CY_CLR  = 3'd5, CY_SET  = 3'd6, CY_FLIP = 3'd7
  } cy_src_e;

  localparam logic [3:0] GRP_CARRY = 4'b0110;
  localparam logic [2:0] GRP_ALU   = 3'b000;
endpackage

// File: rtl/accalu_core.sv
module accalu_core
  import accalu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_fn_e        fn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cout
);
  localparam logic [W:0] ONE = (W+1)'(1);
  logic [W:0] wide;

  always_comb begin
    unique case (fn)
      FN_PASS_A: wide = {1'b0, a};
      FN_NOT_A:  wide = {1'b0, ~a};
      FN_PASS_B: wide = {1'b0, b};
      FN_NOT_B:  wide = {1'b0, ~b};
      FN_ADD:    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      FN_SUB:    wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      FN_AND:    wide = {1'b0, a & b};
      FN_OR:     wide = {1'b0, a | b};
      FN_ROR:    wide = {1'b0, a[0], a[W-1:1]};
      FN_ROL:    wide = {1'b0, a[W-2:0], a[W-1]};
      FN_RORC:   wide = {a[0], cin, a[W-1:1]};
      FN_ROLC:   wide = {a[W-1], a[W-2:0], cin};
      FN_INC_A:  wide = {1'b0, a} + ONE;
      FN_DEC_A:  wide = {1'b0, a} - ONE;
      FN_INC_B:  wide = {1'b0, b} + ONE;
      FN_DEC_B:  wide = {1'b0, b} - ONE;
      default:   wide = '0;
    endcase
  end

  assign res  = wide[W-1:0];
  assign cout = wide[W];
endmodule

// File: rtl/accalu_flags.sv
module accalu_flags
  import accalu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alu_upd,
  input  logic       cy_upd,
  input  cy_src_e    cy_src,
  input  logic       alu_cout,
  input  logic       alu_msb,
  input  logic       alu_zero,
  input  logic [1:0] pin_in,
  input  logic       ptr_eq,
  output logic       c_q,
  output logic       n_q,
  output logic       z_q
);
  logic c_d, n_d, z_d;
  logic c_en, nz_en;

  assign c_en  = alu_upd | cy_upd;
  assign nz_en = alu_upd;

  always_comb begin
    n_d = alu_msb;
    z_d = alu_zero;
    if (alu_upd) begin
      c_d = alu_cout;
    end else begin
      unique case (cy_src)
        CY_PIN0: c_d = pin_in[0];
        CY_PIN1: c_d = pin_in[1];
        CY_NEG:  c_d = n_q;
        CY_ZERO: c_d = z_q;
        CY_PEQ:  c_d = ptr_eq;
        CY_CLR:  c_d = 1'b0;
        CY_SET:  c_d = 1'b1;
        CY_FLIP: c_d = ~c_q;
        default: c_d = c_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      n_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      if (c_en)  c_q <= c_d;
      if (nz_en) begin
        n_q <= n_d;
        z_q <= z_d;
      end
    end
  end
endmodule

// File: rtl/accalu_pins.sv
module accalu_pins #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         sel,
  input  logic               din,
  output logic [NUM_OUT-1:0] pin_q
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
    localparam logic [1:0] IDX = 2'(i);
    logic hit;
    assign hit = wr_en && (sel == IDX);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pin_q[i] <= 1'b0;
      else if (hit) pin_q[i] <= din;
    end
  end
endmodule

// File: rtl/accum_flag_alu.sv
module accum_flag_alu
  import accalu_pkg::*;
#(
  parameter int W       = 8,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         instr,
  input  logic               exec_en,
  input  logic [W-1:0]       a_in,
  input  logic [W-1:0]       b_in,
  input  logic [1:0]         pin_in,
  input  logic               ptr_eq,
  output logic [W-1:0]       res_out,
  output logic               res_wr,
  output logic               res_to_b,
  output logic               flag_c,
  output logic               flag_n,
  output logic               flag_z,
  output logic [NUM_OUT-1:0] pin_out
);
  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_n, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  logic is_alu, is_cgrp, alu_upd, cy_upd, pin_wr, alu_cout;

  assign is_alu  = (instr[7:5] == GRP_ALU);
  assign is_cgrp = (instr[7:4] == GRP_CARRY);
  assign alu_upd = exec_en && is_alu;
  assign cy_upd  = exec_en && is_cgrp && !instr[3];
  assign pin_wr  = exec_en && is_cgrp && (instr[3:2] == 2'b10);

  accalu_core #(.W(W)) u_core (
    .fn   (alu_fn_e'(instr[3:0])),
    .a    (a_in),
    .b    (b_in),
    .cin  (flag_c),
    .res  (res_out),
    .cout (alu_cout)
  );

  accalu_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .alu_upd  (alu_upd),
    .cy_upd   (cy_upd),
    .cy_src   (cy_src_e'(instr[2:0])),
    .alu_cout (alu_cout),
    .alu_msb  (res_out[W-1]),
    .alu_zero (res_out == '0),
    .pin_in   (pin_in),
    .ptr_eq   (ptr_eq),
    .c_q      (flag_c),
    .n_q      (flag_n),
    .z_q      (flag_z)
  );

  accalu_pins #(.NUM_OUT(NUM_OUT)) u_pins (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_en (pin_wr),
    .sel   (instr[1:0]),
    .din   (flag_c),
    .pin_q (pin_out)
  );

  assign res_wr   = alu_upd;
  assign res_to_b = instr[4];
endmodule

// File: rtl/accum_flag_alu_chk.sv
module accum_flag_alu_chk #(
  parameter int W       = 8,
  parameter int NUM_OUT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         instr,
  input logic               exec_en,
  input logic [W-1:0]       res_out,
  input logic               res_wr,
  input logic               flag_c,
  input logic               flag_n,
  input logic               flag_z,
  input logic [NUM_OUT-1:0] pin_out
);
  // R4
  wr_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |-> exec_en);

  // R6
  nz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_wr |=> $stable(flag_n) && $stable(flag_z));

  // R6
  z_follows_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |=> flag_z == ($past(res_out) == '0));

  // R6
  n_follows_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |=> flag_n == $past(res_out[W-1]));

  // R8
  set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && instr == 8'h66 |=> flag_c);

  // R8
  clr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && instr == 8'h65 |=> !flag_c);

  // R10
  idle_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(flag_c));

  // R9
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && instr[7:2] == 6'b011010) |=> $stable(pin_out));

  // R9
  pin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(pin_out ^ $past(pin_out)) <= 1);
endmodule

bind accum_flag_alu accum_flag_alu_chk #(.W(W), .NUM_OUT(NUM_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .instr   (instr),
  .exec_en (exec_en),
  .res_out (res_out),
  .res_wr  (res_wr),
  .flag_c  (flag_c),
  .flag_n  (flag_n),
  .flag_z  (flag_z),
  .pin_out (pin_out)
);

// File: tb/tb_accum_flag_alu.sv
module tb_accum_flag_alu;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] instr, a_in, b_in, res_out;
  logic       exec_en, ptr_eq, res_wr, res_to_b, flag_c, flag_n, flag_z;
  logic [1:0] pin_in;
  logic [3:0] pin_out;

  int n_tests = 0, n_fail = 0;
  logic m_c, m_n, m_z;
  logic [3:0] m_pins;

  always #5 clk = ~clk;

  accum_flag_alu dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .exec_en(exec_en),
    .a_in(a_in), .b_in(b_in), .pin_in(pin_in), .ptr_eq(ptr_eq),
    .res_out(res_out), .res_wr(res_wr), .res_to_b(res_to_b),
    .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z), .pin_out(pin_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (instr %02h)", tag, act, exp, instr);
    end
  endtask

  // returns {carry, result}
  function automatic logic [8:0] ref_alu(input logic [3:0] f, input logic [7:0] a,
                                         input logic [7:0] b, input logic c);
    int s;
    case (f)
      4'h0: return {1'b0, a};
      4'h1: return {1'b0, ~a};
      4'h2: return {1'b0, b};
      4'h3: return {1'b0, ~b};
      4'h4: begin s = int'(a) + int'(b) + int'(c); return {s > 255, s[7:0]}; end
      4'h5: begin s = int'(a) - int'(b) - int'(c); return {s < 0, s[7:0]}; end
      4'h6: return {1'b0, a & b};
      4'h7: return {1'b0, a | b};
      4'h8: return {1'b0, a >> 1 | a << 7};
      4'h9: return {1'b0, a << 1 | a >> 7};
      4'hA: return {a[0], c, a[7:1]};
      4'hB: return {a[7], a[6:0], c};
      4'hC: return {a == 8'hFF, a + 8'd1};
      4'hD: return {a == 8'h00, a - 8'd1};
      4'hE: return {b == 8'hFF, b + 8'd1};
      default: return {b == 8'h00, b - 8'd1};
    endcase
  endfunction

  // entered and left at a falling edge
  task automatic step(input logic [7:0] ins, input logic ex, input logic [7:0] av,
                      input logic [7:0] bv, input logic [1:0] pv, input logic pe);
    logic [8:0] r;
    string rtag, ctag, ptag;
    instr = ins; exec_en = ex; a_in = av; b_in = bv; pin_in = pv; ptr_eq = pe;
    #1;
    r = ref_alu(ins[3:0], av, bv, m_c);
    chk("R4 write strobe", res_wr, ex && ins[7:5] == 3'b000);
    if (ins[7:5] == 3'b000) begin
      rtag = (ins[3:0] < 8) ? "R1 result" : (ins[3:0] < 12) ? "R2 rotate" : "R3 inc/dec";
      chk(rtag, res_out, r[7:0]);
      chk("R4 destination", res_to_b, ins[4]);
    end
    ctag = "R10 carry held"; ptag = "R10 pins held";
    if (ex && ins[7:5] == 3'b000) begin
      m_c = r[8]; m_n = r[7]; m_z = (r[7:0] == 8'h00); ctag = "R5 alu carry";
    end else if (ex && ins[7:4] == 4'b0110) begin
      case (ins[3:0])
        4'h0: begin m_c = pv[0]; ctag = "R7 pin0 to carry"; end
        4'h1: begin m_c = pv[1]; ctag = "R7 pin1 to carry"; end
        4'h2: begin m_c = m_n;   ctag = "R7 N to carry"; end
        4'h3: begin m_c = m_z;   ctag = "R7 Z to carry"; end
        4'h4: begin m_c = pe;    ctag = "R7 P to carry"; end
        4'h5: begin m_c = 1'b0;  ctag = "R8 clear"; end
        4'h6: begin m_c = 1'b1;  ctag = "R8 set"; end
        4'h7: begin m_c = ~m_c;  ctag = "R8 invert"; end
        4'h8, 4'h9, 4'hA, 4'hB: begin
          m_pins[ins[1:0]] = m_c; ptag = "R9 pin latch";
        end
        default: ;
      endcase
    end
    @(negedge clk);
    chk(ctag, flag_c, m_c);
    chk("R6 N flag", flag_n, m_n);
    chk("R6 Z flag", flag_z, m_z);
    chk(ptag, pin_out, m_pins);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; exec_en = 1'b0; instr = 8'h00; a_in = '0; b_in = '0;
    pin_in = '0; ptr_eq = 1'b0;
    m_c = 0; m_n = 0; m_z = 0; m_pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reset C", flag_c, 0);
    chk("R11 reset N", flag_n, 0);
    chk("R11 reset Z", flag_z, 0);
    chk("R11 reset pins", pin_out, 0);

    // directed corners
    step(8'h66, 1, 8'h00, 8'h00, 2'b00, 0);   // set C
    step(8'h04, 1, 8'hFF, 8'h00, 2'b00, 0);   // FF+00+1 = 00, C=1, Z=1
    step(8'h05, 1, 8'h00, 8'h00, 2'b00, 0);   // 00-00-1 borrow
    step(8'h1C, 1, 8'hFF, 8'h11, 2'b00, 0);   // INC A wraps to B
    step(8'h0F, 1, 8'h22, 8'h00, 2'b00, 0);   // DEC B borrow
    step(8'h0A, 1, 8'h01, 8'h00, 2'b00, 0);   // RRC
    step(8'h0B, 1, 8'h80, 8'h00, 2'b00, 0);   // RLC
    step(8'h08, 1, 8'h81, 8'h00, 2'b00, 0);   // RR clears C
    step(8'h67, 1, 8'h00, 8'h00, 2'b00, 0);   // invert C -> 1
    for (int k = 0; k < 4; k++) step(8'h68 | 8'(k), 1, 0, 0, 2'b00, 0);
    step(8'h65, 1, 8'h00, 8'h00, 2'b00, 0);   // clear C
    step(8'h69, 1, 8'h00, 8'h00, 2'b00, 0);   // pin1 <- 0
    step(8'h6C, 1, 8'h00, 8'h00, 2'b11, 1);   // no-op code
    step(8'h6F, 1, 8'h00, 8'h00, 2'b11, 1);   // no-op code
    step(8'h64, 1, 8'h00, 8'h00, 2'b00, 1);   // P to carry
    step(8'h66, 0, 8'h00, 8'h00, 2'b00, 0);   // strobe low: ignored
    step(8'h00, 0, 8'h00, 8'h00, 2'b00, 0);   // strobe low ALU: no flag change
    step(8'h4C, 1, 8'h00, 8'h00, 2'b00, 0);   // other group ignored

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] ins;
      logic ex;
      int kind;
      kind = $urandom_range(0, 7);
      ex = 1'b1;
      case (kind)
        0, 1, 2, 3: ins = {3'b000, 1'($urandom), 4'($urandom)};
        4, 5:       ins = {4'b0110, 4'($urandom)};
        6: begin
          ins = 8'($urandom);
          while (ins[7:5] == 3'b000 || ins[7:4] == 4'b0110) ins = 8'($urandom);
        end
        default: begin ins = 8'($urandom); ex = 1'b0; end
      endcase
      step(ins, ex, 8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom));
    end

    exec_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule